// File: doc/BRIEF.md
# Self-Repairing Checksum Matrix Multiplier

This block multiplies two square fixed-point matrices held in on-chip scratchpads and protects the product with row and column checksums. Software writes operand A and operand B one element at a time through a load port and then pulses start. The block computes every element of C = A×B into a result memory. While it does so, it sums each row and each column of the stored result. It then compares those sums against reference checksums derived from the operands alone. Column references are the column sums of A multiplied into B, and row references are A multiplied into the row sums of B. All sums are carried at full width.

If exactly one row sum and one column sum disagree, the faulty element sits at their crossing. The block turns its row and column index into a memory address, adds the row residue (reference minus observed) to the stored value and writes the repaired value back. Any other disagreement pattern is flagged as uncorrectable, and nothing is written. The number of multiply lanes that work in parallel is chosen per run, which trades cycles against switching activity. A fault-injection mask lets a test corrupt chosen result elements as they are first written.

Top module: `abft_matmul`

## Requirements
- R1: Out of reset, `done`, `corrected` and `uncorrectable` are all low.
- R2: With `ld_en` high in idle, `ld_data` is written to element (`ld_row`,`ld_col`) of A when `ld_sel`=0 or of B when `ld_sel`=1. After a run, every element C(r,c) equals the exact unsigned sum over k of A(r,k)·B(k,c), with no truncation at 2·DW+log2(N) bits. It is read by placing r on `rd_row` and c on `rd_col`; `rd_data` shows it one clock later.
- R3: `lanes` sets how many multiply units work per cycle. A value of 0 acts as 1, and values above P act as P. The results do not depend on it, and a run with more lanes finishes in fewer cycles.
- R4: Bit r·N+c of `fault_map` makes element (r,c) be stored XORed with `fault_xor` when it is first computed.
- R5: When a single element is corrupt, the block recomputes it from the residue and writes it back, so all of C reads correct. After the run, `corrected` is high and `uncorrectable` is low.
- R6: When more than one row or more than one column disagrees, or only one of the two dimensions disagrees, `uncorrectable` goes high and `corrected` stays low. No element is rewritten, so corrupted values remain readable.
- R7: A run without any corruption ends with both `corrected` and `uncorrectable` low.
- R8: `done` rises only after the check and any write-back are complete, and it stays high until the next `start`. A `start` clears `done`, `corrected` and `uncorrectable` on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Operand write strobe (honoured in idle only) |
| ld_sel | input | 1 | 0 selects A, 1 selects B |
| ld_row | input | log2(N) | Operand row index |
| ld_col | input | log2(N) | Operand column index |
| ld_data | input | DW | Operand element value |
| start | input | 1 | Begin a multiply-and-check run |
| lanes | input | log2(P+1) | Requested number of active multiply lanes |
| fault_map | input | N·N | Per-element corruption enable for test |
| fault_xor | input | 2·DW+log2(N) | Corruption pattern |
| rd_row | input | log2(N) | Result read row |
| rd_col | input | log2(N) | Result read column |
| rd_data | output | 2·DW+log2(N) | Registered result element |
| done | output | 1 | Run complete, held until next start |
| corrected | output | 1 | A single element was repaired in the last run |
| uncorrectable | output | 1 | The checksum disagreement pattern could not be repaired |

## Verification
On every cycle, the assertions check that the two outcome flags never coexist and that the repair write happens only when exactly one row and one column disagree. They also check that the lane count in use stays within 1..P, that `done` holds until a start and appears only in idle, and that nothing is written to the result memory while the uncorrectable flag stands. Only the bench scenarios show the arithmetic itself. These scenarios cover exact products for several operand patterns and every lane setting, a repair at every element position with several corruption patterns, and double corruptions that leave the injected values visible. They also cover the relative run lengths for different lane counts.

// File: rtl/abft_pkg.sv
package abft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMP,
    ST_CHK,
    ST_DECIDE,
    ST_FIXWR,
    ST_FIN
  } abft_state_t;
endpackage

// File: rtl/abft_mac_lanes.sv
// P parallel multipliers working on consecutive k terms of one dot product.
module abft_mac_lanes #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int P  = 3,
  parameter int AW = 18,
  parameter int KW = 3,
  parameter int LW = 2
) (
  input  logic [N*DW-1:0] a_row,
  input  logic [N*DW-1:0] b_col,
  input  logic [KW-1:0]   k_base,
  input  logic [LW-1:0]   lanes,
  output logic [AW-1:0]   part
);
  logic [AW-1:0] prods [P];

  for (genvar l = 0; l < P; l++) begin : g_lane
    always_comb begin
      int kk;
      kk = int'(k_base) + l;
      if (l < int'(lanes) && kk < N)
        prods[l] = AW'(a_row[kk*DW +: DW]) * AW'(b_col[kk*DW +: DW]);
      else
        prods[l] = '0;
    end
  end

  always_comb begin
    part = '0;
    for (int l = 0; l < P; l++) part = part + prods[l];
  end
endmodule

// File: rtl/abft_checksum.sv
// Reference row/column checksums of C derived from the operands only.
module abft_checksum #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int CW = 20,
  parameter int RW = 2
) (
  input  logic [N*N*DW-1:0] a_flat,
  input  logic [N*N*DW-1:0] b_flat,
  input  logic [RW-1:0]     idx,
  output logic [CW-1:0]     ref_row,
  output logic [CW-1:0]     ref_col
);
  logic [CW-1:0] a_colsum [N];
  logic [CW-1:0] b_rowsum [N];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      a_colsum[k] = '0;
      b_rowsum[k] = '0;
      for (int t = 0; t < N; t++) begin
        a_colsum[k] = a_colsum[k] + CW'(a_flat[(t*N+k)*DW +: DW]);
        b_rowsum[k] = b_rowsum[k] + CW'(b_flat[(k*N+t)*DW +: DW]);
      end
    end
  end

  always_comb begin
    ref_row = '0;
    ref_col = '0;
    for (int k = 0; k < N; k++) begin
      ref_row = ref_row + CW'(a_flat[(int'(idx)*N+k)*DW +: DW]) * b_rowsum[k];
      ref_col = ref_col + a_colsum[k] * CW'(b_flat[(k*N+int'(idx))*DW +: DW]);
    end
  end
endmodule

// File: rtl/abft_result_mem.sv
// Result store: one write port, two registered read ports.
module abft_result_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 18,
  parameter int ABITS = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ABITS-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [ABITS-1:0] ra_addr,
  output logic [W-1:0]     ra_data,
  input  logic [ABITS-1:0] rb_addr,
  output logic [W-1:0]     rb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/abft_matmul.sv
module abft_matmul
  import abft_pkg::*;
#(
  parameter  int N  = 4,
  parameter  int DW = 8,
  parameter  int P  = 3,
  localparam int RW = $clog2(N),
  localparam int LW = $clog2(P + 1),
  localparam int AW = 2 * DW + $clog2(N),
  localparam int NE = N * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [RW-1:0] ld_row,
  input  logic [RW-1:0] ld_col,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  input  logic [LW-1:0] lanes,
  input  logic [NE-1:0] fault_map,
  input  logic [AW-1:0] fault_xor,
  input  logic [RW-1:0] rd_row,
  input  logic [RW-1:0] rd_col,
  output logic [AW-1:0] rd_data,
  output logic          done,
  output logic          corrected,
  output logic          uncorrectable
);
  localparam int CW = AW + $clog2(N);
  localparam int EW = $clog2(NE);
  localparam int KW = $clog2(N + P + 1);

  abft_state_t   state;
  logic [NE*DW-1:0] a_sp, b_sp;
  logic [RW-1:0] ri, cj, mi, bad_r, bad_c;
  logic [KW-1:0] kb;
  logic [LW-1:0] lanes_q, lanes_cl;
  logic [AW-1:0] acc, part, elem_val, fix_old, mem_wdata;
  logic [CW-1:0] obs_row [N];
  logic [CW-1:0] obs_col [N];
  logic [CW-1:0] ref_row, ref_col, residue;
  logic [1:0]    rcnt, ccnt;
  logic          last_k, mem_we;
  logic [EW-1:0] cur_addr, fix_addr, mem_waddr, rd_addr;
  logic [N*DW-1:0] a_row, b_col;
  logic          done_q, corr_q, unc_q;

  // Operand scratchpads, written only while idle
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && ld_en) begin
      if (!ld_sel) a_sp[(int'(ld_row)*N + int'(ld_col))*DW +: DW] <= ld_data;
      else         b_sp[(int'(ld_row)*N + int'(ld_col))*DW +: DW] <= ld_data;
    end
  end

  always_comb begin
    a_row = a_sp[int'(ri)*N*DW +: N*DW];
    for (int k = 0; k < N; k++) b_col[k*DW +: DW] = b_sp[(k*N + int'(cj))*DW +: DW];
  end

  always_comb begin
    if (lanes == '0)            lanes_cl = LW'(1);
    else if (int'(lanes) > P)   lanes_cl = LW'(P);
    else                        lanes_cl = lanes;
  end

  abft_mac_lanes #(.N(N), .DW(DW), .P(P), .AW(AW), .KW(KW), .LW(LW)) u_mac (
    .a_row(a_row), .b_col(b_col), .k_base(kb), .lanes(lanes_q), .part(part)
  );

  abft_checksum #(.N(N), .DW(DW), .CW(CW), .RW(RW)) u_chk (
    .a_flat(a_sp), .b_flat(b_sp), .idx(mi), .ref_row(ref_row), .ref_col(ref_col)
  );

  always_comb begin
    last_k    = (int'(kb) + int'(lanes_q) >= N);
    cur_addr  = EW'(int'(ri)*N + int'(cj));
    fix_addr  = EW'(int'(bad_r)*N + int'(bad_c));
    rd_addr   = EW'(int'(rd_row)*N + int'(rd_col));
    elem_val  = (acc + part) ^ (fault_map[cur_addr] ? fault_xor : '0);
    mem_we    = (state == ST_COMP && last_k) || (state == ST_FIXWR);
    mem_waddr = (state == ST_FIXWR) ? fix_addr : cur_addr;
    mem_wdata = (state == ST_FIXWR) ? fix_old + AW'(residue) : elem_val;
  end

  abft_result_mem #(.DEPTH(NE), .W(AW), .ABITS(EW)) u_cmem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra_addr(rd_addr), .ra_data(rd_data), .rb_addr(fix_addr), .rb_data(fix_old)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done_q  <= 1'b0;
      corr_q  <= 1'b0;
      unc_q   <= 1'b0;
      ri      <= '0;
      cj      <= '0;
      mi      <= '0;
      kb      <= '0;
      acc     <= '0;
      lanes_q <= LW'(1);
      rcnt    <= '0;
      ccnt    <= '0;
      bad_r   <= '0;
      bad_c   <= '0;
      residue <= '0;
      for (int n = 0; n < N; n++) begin
        obs_row[n] <= '0;
        obs_col[n] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          done_q  <= 1'b0;
          corr_q  <= 1'b0;
          unc_q   <= 1'b0;
          ri      <= '0;
          cj      <= '0;
          kb      <= '0;
          acc     <= '0;
          rcnt    <= '0;
          ccnt    <= '0;
          lanes_q <= lanes_cl;
          for (int n = 0; n < N; n++) begin
            obs_row[n] <= '0;
            obs_col[n] <= '0;
          end
          state <= ST_COMP;
        end
        ST_COMP: begin
          if (last_k) begin
            acc         <= '0;
            kb          <= '0;
            obs_row[ri] <= obs_row[ri] + CW'(elem_val);
            obs_col[cj] <= obs_col[cj] + CW'(elem_val);
            if (cj == RW'(N-1)) begin
              cj <= '0;
              if (ri == RW'(N-1)) begin
                ri    <= '0;
                mi    <= '0;
                state <= ST_CHK;
              end else begin
                ri <= ri + 1'b1;
              end
            end else begin
              cj <= cj + 1'b1;
            end
          end else begin
            acc <= acc + part;
            kb  <= kb + KW'(lanes_q);
          end
        end
        ST_CHK: begin
          if (ref_row != obs_row[mi]) begin
            rcnt    <= (rcnt == 2'd2) ? 2'd2 : rcnt + 2'd1;
            bad_r   <= mi;
            residue <= ref_row - obs_row[mi];
          end
          if (ref_col != obs_col[mi]) begin
            ccnt  <= (ccnt == 2'd2) ? 2'd2 : ccnt + 2'd1;
            bad_c <= mi;
          end
          if (mi == RW'(N-1)) state <= ST_DECIDE;
          else                mi    <= mi + 1'b1;
        end
        ST_DECIDE: begin
          if (rcnt == 2'd0 && ccnt == 2'd0) begin
            state <= ST_FIN;
          end else if (rcnt == 2'd1 && ccnt == 2'd1) begin
            state <= ST_FIXWR;
          end else begin
            unc_q <= 1'b1;
            state <= ST_FIN;
          end
        end
        ST_FIXWR: begin
          corr_q <= 1'b1;
          state  <= ST_FIN;
        end
        ST_FIN: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done          = done_q;
  assign corrected     = corr_q;
  assign uncorrectable = unc_q;

  // R5/R6: outcome flags are exclusive
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(corr_q && unc_q));
  // R3: the captured lane count is always within 1..P while computing
  a_r3_lane_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMP) |-> (lanes_q != '0 && int'(lanes_q) <= P));
  // R5: repair write only with exactly one bad row and one bad column
  a_r5_single_fix: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIXWR) |-> (rcnt == 2'd1 && ccnt == 2'd1));
  // R5: the repair flag rises before done
  a_r5_fix_before_done: assert property (@(posedge clk) disable iff (rst)
    $rose(corr_q) |-> !done_q);
  // R6: nothing is written while the uncorrectable flag stands
  a_r6_no_writeback: assert property (@(posedge clk) disable iff (rst)
    unc_q |-> !mem_we);
  // R8: done holds until a start
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q);
  // R8: done only in idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state == ST_IDLE));
endmodule

// File: tb/tb_abft_matmul.sv
module tb_abft_matmul;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, ld_en, ld_sel, start, done, corrected, uncorrectable;
  logic [1:0] ld_row, ld_col, rd_row, rd_col, lanes;
  logic [DW-1:0] ld_data;
  logic [15:0] fault_map;
  logic [AW-1:0] fault_xor, rd_data;

  abft_matmul #(.N(N), .DW(DW), .P(3)) dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_row(ld_row),
    .ld_col(ld_col), .ld_data(ld_data), .start(start), .lanes(lanes),
    .fault_map(fault_map), .fault_xor(fault_xor), .rd_row(rd_row),
    .rd_col(rd_col), .rd_data(rd_data), .done(done), .corrected(corrected),
    .uncorrectable(uncorrectable)
  );

  int errs = 0;
  int checks = 0;
  int am [4][4];
  int bm [4][4];
  int cm [4][4];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  function automatic int gen(int pat, int sel, int r, int c);
    case (pat)
      0: gen = sel ? ((r == c) ? 3 : r + c) : r*4 + c + 1;
      1: gen = 255;
      2: gen = $urandom_range(255);
      default: gen = sel ? (r*c*17) % 256 : ((r + c) % 2) * 255;
    endcase
  endfunction

  task automatic load(input int pat);
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          int v;
          v = gen(pat, s, r, c);
          if (s == 0) am[r][c] = v; else bm[r][c] = v;
          @(negedge clk);
          ld_en = 1'b1; ld_sel = s[0]; ld_row = r[1:0]; ld_col = c[1:0];
          ld_data = v[7:0];
        end
    @(negedge clk);
    ld_en = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        cm[r][c] = 0;
        for (int k = 0; k < N; k++) cm[r][c] += am[r][k] * bm[k][c];
      end
  endtask

  task automatic run(input int ln, input logic [15:0] fm, input logic [AW-1:0] fx,
                     output int cyc);
    @(negedge clk);
    lanes = ln[1:0]; fault_map = fm; fault_xor = fx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8", "done cleared after start", int'(done), 0);
    chk(corrected == 1'b0 && uncorrectable == 1'b0, "R8", "flags cleared after start",
        int'(corrected) + int'(uncorrectable), 0);
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R8", "done reached", int'(done), 1);
  endtask

  task automatic verify(input string req, input logic [15:0] fm, input logic [AW-1:0] fx);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int exp;
        exp = cm[r][c] ^ (fm[r*4+c] ? int'(fx) : 0);
        @(negedge clk);
        rd_row = r[1:0]; rd_col = c[1:0];
        @(negedge clk);
        chk(int'(rd_data) == exp, req, $sformatf("C(%0d,%0d)", r, c), int'(rd_data), exp);
      end
  endtask

  initial begin
    int cyc [4];
    int t;
    logic [AW-1:0] masks [3];
    logic [15:0] pairs [4];
    masks[0] = 18'h00001; masks[1] = 18'h2AB55; masks[2] = 18'h20000;
    pairs[0] = 16'h0021; pairs[1] = 16'h1008; pairs[2] = 16'h0006; pairs[3] = 16'h0110;
    rst = 1'b1; ld_en = 1'b0; ld_sel = 1'b0; ld_row = '0; ld_col = '0; ld_data = '0;
    start = 1'b0; lanes = 2'd1; fault_map = '0; fault_xor = '0; rd_row = '0; rd_col = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(corrected == 1'b0, "R1", "corrected after reset", int'(corrected), 0);
    chk(uncorrectable == 1'b0, "R1", "uncorrectable after reset", int'(uncorrectable), 0);

    // R2, R3, R7: clean runs over several operand patterns and every lane setting
    for (int pat = 0; pat < 4; pat++) begin
      load(pat);
      for (int ln = 0; ln < 4; ln++) begin
        run(ln, '0, '0, cyc[ln]);
        verify("R2", '0, '0);
        chk(corrected == 1'b0, "R7", "no repair on clean run", int'(corrected), 0);
        chk(uncorrectable == 1'b0, "R7", "no flag on clean run", int'(uncorrectable), 0);
      end
      chk(cyc[3] < cyc[1], "R3", "three lanes faster than one", cyc[3], cyc[1]);
      chk(cyc[0] == cyc[1], "R3", "zero lanes acts as one", cyc[0], cyc[1]);
    end

    // R5: a repair at every element position with several patterns
    load(2);
    for (int pos = 0; pos < 16; pos++)
      for (int m = 0; m < 3; m++) begin
        logic [15:0] fm;
        fm = 16'(1) << pos;
        run((pos + m) % 4, fm, masks[m], t);
        chk(corrected == 1'b1, "R5", $sformatf("repair flag pos %0d", pos), int'(corrected), 1);
        chk(uncorrectable == 1'b0, "R5", "no uncorrectable on single fault",
            int'(uncorrectable), 0);
        verify("R5", '0, '0);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R8", "done held in idle", int'(done), 1);
      end

    // R4, R6: double corruption is flagged and left in place
    for (int p = 0; p < 4; p++) begin
      run(3, pairs[p], masks[p % 3], t);
      chk(uncorrectable == 1'b1, "R6", $sformatf("flag for pair %0d", p),
          int'(uncorrectable), 1);
      chk(corrected == 1'b0, "R6", "no repair on double fault", int'(corrected), 0);
      verify("R4", pairs[p], masks[p % 3]);
    end

    // R7, R8: flags cleared by the next clean run
    run(2, '0, '0, t);
    chk(uncorrectable == 1'b0, "R8", "flag cleared on next run", int'(uncorrectable), 0);
    verify("R7", '0, '0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule